// File: doc/BRIEF.md
# Low-Address Guard and Prefix Relocator

This block sits on the real-address side of a processor's memory path. For each access it takes a 64-bit address, the kind of access (read, store or instruction fetch), whether dynamic address translation is on, the selected address space and a few control bits. It then decides three things. First, whether a store hits the protected low storage range. Second, whether the page holding the address must never be kept in a translation cache with write permission. Third, what absolute address the real address becomes once the per-processor prefix swap is applied.

The prefix swap exchanges two 8 KB windows. One window starts at address zero and the other starts at a movable, 8 KB aligned prefix base. The prefix base is held in a register inside the block and is loaded through a simple write port. All other results are combinational, so they are valid in the same cycle as the address and controls.

Table walks, storage keys and the delivery of program exceptions belong to other blocks.

Top module: `lowaddr_guard_mapper`

## Requirements
- R1: With protection active, a store (`acc_type` = 2'b01) faults exactly when its byte address lies in 0..511 or 4096..4607. The addresses 512, 4095 and 4608 do not fault.
- R2: When `cr0_lowprot` is 0, `prot_fault` and `write_inv` stay 0 for every address and access kind.
- R3: When `xlate_on` is 0 and `cr0_lowprot` is 1, protection is active whatever the space mode and the three private bits are.
- R4: When `xlate_on` is 1, protection is active only if the private bit of the selected space is 0. The space is selected by `space_mode`: 2'b00 primary (`prv_primary`), 2'b10 secondary (`prv_secondary`), 2'b11 home (`prv_home`). The private bits of the spaces that are not selected have no effect.
- R5: When `xlate_on` is 1 and `space_mode` is 2'b01, `mode_err` is 1, `abs_valid` is 0 and `prot_fault` is 0.
- R6: Reads (2'b00) and fetches (2'b10) never raise `prot_fault`, even inside the protected range.
- R7: While `prot_fault` is 1, `abs_valid` is 0 and `abs_addr` is all zeros, so no translation result is given.
- R8: With protection active, `write_inv` is 1 for any access kind whose 4 KB-aligned address lies in the protected range. For example, 600 and 0x1FFF set it, but 0x2000 does not.
- R9: A real address below 0x2000 maps to that address plus the prefix base.
- R10: A real address from the prefix base up to the prefix base plus 0x1FFF maps to that address minus the prefix base. Any other address passes through unchanged.
- R11: The prefix base resets to zero on a clock edge with `rst_n` low. A write with `pfx_wr_en` high takes effect from the next edge onward. Bits 12..0 of `pfx_wr_data` are dropped.
- R12: `prot_fault`, `write_inv`, `mode_err`, `abs_valid` and `abs_addr` follow the address and controls in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the prefix register |
| rst_n | input | 1 | Synchronous active-low reset |
| pfx_wr_en | input | 1 | Load the prefix base |
| pfx_wr_data | input | 64 | New prefix base; the low 13 bits are ignored |
| addr | input | 64 | Real byte address of the access |
| acc_type | input | 2 | 00 read, 01 store, 10 fetch |
| xlate_on | input | 1 | Dynamic address translation enabled |
| space_mode | input | 2 | 00 primary, 01 unsupported, 10 secondary, 11 home |
| cr0_lowprot | input | 1 | Low-address protection enable |
| prv_primary | input | 1 | Private bit of the primary space descriptor |
| prv_secondary | input | 1 | Private bit of the secondary space descriptor |
| prv_home | input | 1 | Private bit of the home space descriptor |
| prot_fault | output | 1 | Store into the protected range |
| write_inv | output | 1 | Page must not be cached as writable |
| mode_err | output | 1 | Unsupported space mode with translation on |
| abs_valid | output | 1 | `abs_addr` holds a result |
| abs_addr | output | 64 | Absolute address after the prefix swap |

## Verification
Every output except the prefix base is due in the same cycle as its stimulus. The bench therefore changes inputs on the falling edge and samples one nanosecond later, with no clock edge in between. A prefix write is due one rising edge after it is presented. The bench samples the mapping once before that edge, to confirm the old base still applies, and again on the following falling edge, to confirm the new base is in use. Boundary addresses on both sides of each protected window and both prefix windows are applied one at a time, so every sample reflects a single known stimulus.

// File: rtl/lap_pkg.sv
// Package: shared encodings for the low-address guard and prefix relocator.
// Assumes the access and space encodings below are fixed by the requester.
package lap_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        SP_PRIMARY   = 2'b00,
        SP_ACCREG    = 2'b01,
        SP_SECONDARY = 2'b10,
        SP_HOME      = 2'b11
    } space_e;

endpackage

// File: rtl/lap_low_range.sv
// Module: lap_low_range
// Detects whether an address falls in the protected low range. The range is
// the first LOW_SPAN bytes of each of the first LOW_PAGES pages.
// Assumes LOW_SPAN does not exceed the page size.
module lap_low_range #(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12,
    parameter int LOW_SPAN  = 512,
    parameter int LOW_PAGES = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int HI_W = ADDR_W - PAGE_BITS;

    logic [LOW_PAGES-1:0] win_hit;
    logic [PAGE_BITS:0]   offs;

    // Offset within the page, widened so the compare against LOW_SPAN fits.
    always_comb offs = {1'b0, addr[PAGE_BITS-1:0]};

    // One comparator per protected page.
    for (genvar g = 0; g < LOW_PAGES; g++) begin : g_win
        always_comb win_hit[g] = (addr[ADDR_W-1:PAGE_BITS] == HI_W'(g)) &&
                                 (offs < (PAGE_BITS+1)'(LOW_SPAN));
    end

    // Any window hit counts as a hit.
    always_comb hit = |win_hit;

endmodule

// File: rtl/lap_guard.sv
// Module: lap_guard
// Decides whether low-address protection is in force for this access. From
// that it raises the store fault, the write-invalidate flag and the
// unsupported-mode error. Assumes both range flags come from lap_low_range.
module lap_guard
    import lap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] acc_type,
    input  logic       xlate_on,
    input  logic [1:0] space_mode,
    input  logic       cr0_lowprot,
    input  logic       prv_primary,
    input  logic       prv_secondary,
    input  logic       prv_home,
    input  logic       byte_hit,
    input  logic       page_hit,
    output logic       fault,
    output logic       winv,
    output logic       mode_err
);
    acc_kind_e acc;
    space_e    space;
    logic      prv_sel;
    logic      active;

    // Decode the raw port codes into the package types.
    always_comb begin
        acc   = acc_kind_e'(acc_type);
        space = space_e'(space_mode);
    end

    // Pick the private bit of the space descriptor selected by the mode.
    always_comb begin
        unique case (space)
            SP_PRIMARY:   prv_sel = prv_primary;
            SP_SECONDARY: prv_sel = prv_secondary;
            SP_HOME:      prv_sel = prv_home;
            default:      prv_sel = 1'b1;
        endcase
    end

    // Flag the unsupported space mode; it matters only with translation on.
    always_comb mode_err = xlate_on && (space == SP_ACCREG);

    // Protection is in force if enabled and either translation is off or the
    // selected space is not private.
    always_comb active = cr0_lowprot && (!xlate_on || (!mode_err && !prv_sel));

    // Fault on a store whose own byte address is protected.
    always_comb fault = active && byte_hit && (acc == ACC_STORE);

    // Mark the whole page as unsafe to cache writable.
    always_comb winv = active && page_hit;

    AST_FAULT_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (acc_type == 2'b01)); // R6
    AST_FAULT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !cr0_lowprot |-> (!fault && !winv)); // R2
    AST_FAULT_IMPLIES_WINV: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> winv); // R8
    AST_MODE_ERR_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !fault); // R5

endmodule

// File: rtl/lap_prefix_map.sv
// Module: lap_prefix_map
// Holds the prefix base and swaps the window at address zero with the
// window at the prefix base. Assumes the base is aligned to the window,
// which the write port enforces by dropping the low bits.
module lap_prefix_map #(
    parameter int ADDR_W   = 64,
    parameter int WIN_BITS = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] real_addr,
    output logic [ADDR_W-1:0] abs_addr
);
    localparam int HI_W = ADDR_W - WIN_BITS;

    logic [HI_W-1:0] pfx_hi;
    logic [HI_W-1:0] ra_hi;
    logic            in_zero;
    logic            in_pfx;

    // Prefix base register: synchronous active-low reset, aligned load.
    always_ff @(posedge clk) begin
        if (!rst_n)     pfx_hi <= '0;
        else if (wr_en) pfx_hi <= wr_data[ADDR_W-1:WIN_BITS];
    end

    // Window-number compares; the aligned base means no carry is needed.
    always_comb begin
        ra_hi   = real_addr[ADDR_W-1:WIN_BITS];
        in_zero = (ra_hi == '0);
        in_pfx  = (ra_hi == pfx_hi);
    end

    // Swap the window number; the zero window wins if both match.
    always_comb begin
        if (in_zero)     abs_addr = {pfx_hi, real_addr[WIN_BITS-1:0]};
        else if (in_pfx) abs_addr = {{HI_W{1'b0}}, real_addr[WIN_BITS-1:0]};
        else             abs_addr = real_addr;
    end

    AST_PFX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pfx_hi)); // R11
    AST_PFX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pfx_hi == $past(wr_data[ADDR_W-1:WIN_BITS]))); // R11
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        abs_addr[WIN_BITS-1:0] == real_addr[WIN_BITS-1:0]); // R10

endmodule

// File: rtl/lowaddr_guard_mapper.sv
// Module: lowaddr_guard_mapper (top)
// Real-address stage: low-address protection, the write-invalidate hint and
// the prefix swap to an absolute address. Everything is combinational
// except the prefix base register.
// Assumes the requester drives a stable address and controls for the cycle.
module lowaddr_guard_mapper
    import lap_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12,
    parameter int LOW_SPAN  = 512,
    parameter int LOW_PAGES = 2,
    parameter int WIN_BITS  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pfx_wr_en,
    input  logic [ADDR_W-1:0] pfx_wr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        acc_type,
    input  logic              xlate_on,
    input  logic [1:0]        space_mode,
    input  logic              cr0_lowprot,
    input  logic              prv_primary,
    input  logic              prv_secondary,
    input  logic              prv_home,
    output logic              prot_fault,
    output logic              write_inv,
    output logic              mode_err,
    output logic              abs_valid,
    output logic [ADDR_W-1:0] abs_addr
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ~((ADDR_W)'((1 << PAGE_BITS) - 1));

    logic [ADDR_W-1:0] page_addr;
    logic              byte_hit;
    logic              page_hit;
    logic [ADDR_W-1:0] mapped;

    // Page-aligned copy of the address for the write-invalidate test.
    always_comb page_addr = addr & PAGE_MASK;

    lap_low_range #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .LOW_SPAN(LOW_SPAN), .LOW_PAGES(LOW_PAGES)
    ) u_byte_rng (
        .addr (addr),
        .hit  (byte_hit)
    );

    lap_low_range #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
        .LOW_SPAN(LOW_SPAN), .LOW_PAGES(LOW_PAGES)
    ) u_page_rng (
        .addr (page_addr),
        .hit  (page_hit)
    );

    lap_guard u_guard (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_type      (acc_type),
        .xlate_on      (xlate_on),
        .space_mode    (space_mode),
        .cr0_lowprot   (cr0_lowprot),
        .prv_primary   (prv_primary),
        .prv_secondary (prv_secondary),
        .prv_home      (prv_home),
        .byte_hit      (byte_hit),
        .page_hit      (page_hit),
        .fault         (prot_fault),
        .winv          (write_inv),
        .mode_err      (mode_err)
    );

    lap_prefix_map #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)
    ) u_pfx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (pfx_wr_en),
        .wr_data   (pfx_wr_data),
        .real_addr (addr),
        .abs_addr  (mapped)
    );

    // Release a result only when neither a fault nor a mode error stands.
    always_comb begin
        abs_valid = !prot_fault && !mode_err;
        abs_addr  = abs_valid ? mapped : '0;
    end

    AST_NO_RESULT_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (!abs_valid && (abs_addr == '0))); // R7
    AST_MODE_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_err |-> !abs_valid); // R5
    AST_FAULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        prot_fault |-> (addr < (ADDR_W)'(2 << PAGE_BITS))); // R1

endmodule

// File: tb/tb_lowaddr_guard_mapper.sv
// Directed bench: each task applies one scenario and checks its results.
module tb_lowaddr_guard_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pfx_wr_en = 1'b0;
    logic [63:0] pfx_wr_data = '0;
    logic [63:0] addr = '0;
    logic [1:0]  acc_type = 2'b00;
    logic        xlate_on = 1'b0;
    logic [1:0]  space_mode = 2'b00;
    logic        cr0_lowprot = 1'b0;
    logic        prv_primary = 1'b0;
    logic        prv_secondary = 1'b0;
    logic        prv_home = 1'b0;
    logic        prot_fault, write_inv, mode_err, abs_valid;
    logic [63:0] abs_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lowaddr_guard_mapper dut (
        .clk(clk), .rst_n(rst_n), .pfx_wr_en(pfx_wr_en), .pfx_wr_data(pfx_wr_data),
        .addr(addr), .acc_type(acc_type), .xlate_on(xlate_on), .space_mode(space_mode),
        .cr0_lowprot(cr0_lowprot), .prv_primary(prv_primary),
        .prv_secondary(prv_secondary), .prv_home(prv_home),
        .prot_fault(prot_fault), .write_inv(write_inv), .mode_err(mode_err),
        .abs_valid(abs_valid), .abs_addr(abs_addr)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one access on the falling edge and let it settle for 1 ns.
    task automatic apply(input logic [63:0] a, input logic [1:0] acc, input logic xl,
                         input logic [1:0] md, input logic en,
                         input logic p1, input logic p7, input logic p13);
        @(negedge clk);
        addr = a; acc_type = acc; xlate_on = xl; space_mode = md;
        cr0_lowprot = en; prv_primary = p1; prv_secondary = p7; prv_home = p13;
        #1;
    endtask

    task automatic t_reset;
        apply(64'h100, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R11", "reset base maps low addr to itself", abs_addr, 64'h100);
        chk("R11", "valid after reset", {63'b0, abs_valid}, 64'd1);
        chk("R2", "no fault after reset", {63'b0, prot_fault}, 64'd0);
    endtask

    task automatic t_prefix;
        @(negedge clk);
        pfx_wr_en = 1'b1; pfx_wr_data = 64'h0000_0000_0012_3FFF;
        addr = 64'h40; #1;
        chk("R11", "old base before edge", abs_addr, 64'h40);
        @(negedge clk);
        pfx_wr_en = 1'b0; #1;
        chk("R11", "new base after edge, low bits dropped", abs_addr, 64'h122040);
        apply(64'h0, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R9", "0x0", abs_addr, 64'h122000);
        apply(64'h1FFF, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R9", "0x1FFF", abs_addr, 64'h123FFF);
        apply(64'h2000, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R10", "0x2000 passes", abs_addr, 64'h2000);
        apply(64'h122000, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R10", "base maps to zero", abs_addr, 64'h0);
        apply(64'h123FFF, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R10", "top of prefix window", abs_addr, 64'h1FFF);
        apply(64'h124000, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R10", "above prefix window", abs_addr, 64'h124000);
        apply(64'h121FFF, 2'b00, 0, 2'b00, 0, 0, 0, 0);
        chk("R10", "below prefix window", abs_addr, 64'h121FFF);
    endtask

    task automatic t_range;
        apply(64'd0, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R1", "store 0", {63'b0, prot_fault}, 64'd1);
        chk("R7", "no result at 0", abs_addr, 64'd0);
        chk("R7", "invalid at 0", {63'b0, abs_valid}, 64'd0);
        apply(64'd511, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R1", "store 511", {63'b0, prot_fault}, 64'd1);
        apply(64'd512, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R1", "store 512", {63'b0, prot_fault}, 64'd0);
        chk("R9", "512 relocated", abs_addr, 64'h122200);
        apply(64'd4095, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R1", "store 4095", {63'b0, prot_fault}, 64'd0);
        apply(64'd4096, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R1", "store 4096", {63'b0, prot_fault}, 64'd1);
        apply(64'd4607, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R1", "store 4607", {63'b0, prot_fault}, 64'd1);
        apply(64'd4608, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R1", "store 4608", {63'b0, prot_fault}, 64'd0);
        chk("R12", "4608 result same cycle", abs_addr, 64'h123200);
    endtask

    task automatic t_access;
        apply(64'd0, 2'b00, 0, 2'b00, 1, 0, 0, 0);
        chk("R6", "read 0", {63'b0, prot_fault}, 64'd0);
        apply(64'd4100, 2'b10, 0, 2'b00, 1, 0, 0, 0);
        chk("R6", "fetch 4100", {63'b0, prot_fault}, 64'd0);
        chk("R6", "fetch result", abs_addr, 64'h123004);
    endtask

    task automatic t_enable;
        apply(64'd0, 2'b01, 0, 2'b00, 0, 0, 0, 0);
        chk("R2", "store 0 disabled", {63'b0, prot_fault}, 64'd0);
        chk("R2", "no winv disabled", {63'b0, write_inv}, 64'd0);
    endtask

    task automatic t_xlate;
        apply(64'd8, 2'b01, 0, 2'b01, 1, 1, 1, 1);
        chk("R3", "xlate off ignores private bits", {63'b0, prot_fault}, 64'd1);
        apply(64'd8, 2'b01, 1, 2'b00, 1, 1, 0, 0);
        chk("R4", "primary private", {63'b0, prot_fault}, 64'd0);
        apply(64'd8, 2'b01, 1, 2'b00, 1, 0, 1, 1);
        chk("R4", "primary, others private", {63'b0, prot_fault}, 64'd1);
        apply(64'd8, 2'b01, 1, 2'b10, 1, 1, 0, 1);
        chk("R4", "secondary not private", {63'b0, prot_fault}, 64'd1);
        apply(64'd8, 2'b01, 1, 2'b10, 1, 0, 1, 0);
        chk("R4", "secondary private", {63'b0, prot_fault}, 64'd0);
        apply(64'd8, 2'b01, 1, 2'b11, 1, 1, 1, 0);
        chk("R4", "home not private", {63'b0, prot_fault}, 64'd1);
        apply(64'd8, 2'b01, 1, 2'b11, 1, 0, 0, 1);
        chk("R4", "home private", {63'b0, prot_fault}, 64'd0);
    endtask

    task automatic t_mode_err;
        apply(64'd8, 2'b01, 1, 2'b01, 1, 0, 0, 0);
        chk("R5", "mode_err", {63'b0, mode_err}, 64'd1);
        chk("R5", "no valid", {63'b0, abs_valid}, 64'd0);
        chk("R5", "no fault", {63'b0, prot_fault}, 64'd0);
        apply(64'd8, 2'b01, 0, 2'b01, 0, 0, 0, 0);
        chk("R5", "no mode_err with xlate off", {63'b0, mode_err}, 64'd0);
    endtask

    task automatic t_winv;
        apply(64'd600, 2'b01, 0, 2'b00, 1, 0, 0, 0);
        chk("R8", "store 600 no fault", {63'b0, prot_fault}, 64'd0);
        chk("R8", "store 600 winv", {63'b0, write_inv}, 64'd1);
        apply(64'h1FFF, 2'b00, 0, 2'b00, 1, 0, 0, 0);
        chk("R8", "read 0x1FFF winv", {63'b0, write_inv}, 64'd1);
        apply(64'h2000, 2'b00, 0, 2'b00, 1, 0, 0, 0);
        chk("R8", "read 0x2000 no winv", {63'b0, write_inv}, 64'd0);
        apply(64'd8, 2'b00, 1, 2'b00, 1, 1, 0, 0);
        chk("R8", "private space no winv", {63'b0, write_inv}, 64'd0);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prefix();
        t_range();
        t_access();
        t_enable();
        t_xlate();
        t_mode_err();
        t_winv();
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

endmodule